// File: doc/BRIEF.md
# Indirect-Address Cartridge Mapper

This block sits on the cartridge side of an 8-bit console CPU bus. It provides a narrow window through which a program reaches a large external ROM and an external RAM one byte at a time. Two 8-bit pointer registers, low and high, together form a 16-bit pointer into those memories. A register loads from the data bus whenever a qualifying bus cycle has the matching address line set. The direction of the cycle plays no part in this, so a read also loads the register, taking the byte that is on the bus at that moment.

A qualifying cycle is one with ROM-select asserted (active low), A12 high and M2 high. On such a cycle with A11 high, the block drives one of two external chip selects: A2 low picks the ROM and A2 high picks the RAM. The external address is made of CPU A0 on top, then the high register, then the low register. The upper nibble of the high register also drives a 4-bit CHR RAM bank. The registers are sampled flops on the system clock. Each one captures the bus while its enable is true and keeps its last captured value once M2 falls.

Top module: `indirect_mapper`

## Requirements
- R1: Registers load and chip selects go active only when romsel_n=0, a12=1 and m2=1 all hold. If any of the three is missing, the registers keep their value and both chip selects stay high.
- R2: A qualifying cycle with a4=1 loads d into the low register, which appears on ext_addr[7:0] from the next clock onward.
- R3: A qualifying cycle with a5=1 loads d into the high register, which appears on ext_addr[15:8] from the next clock onward.
- R4: The rw level has no effect on register loading: a read (rw=1) loads exactly as a write does.
- R5: With a4=1 and a5=1 in the same qualifying cycle, both registers take the same byte.
- R6: On a qualifying cycle with a11=1, a2=0 drives rom_cs_n low and a2=1 drives ram_cs_n low. The two are never low together, and both are high when a11=0.
- R7: ext_addr[16] equals a0 at all times.
- R8: ram_we_n is low only while ram_cs_n is low and rw=0.
- R9: chr_bank equals bits 7:4 of the high register.
- R10: After m2 falls, both registers keep their last loaded values.
- R11: A synchronous reset clears both registers to 0x00.
- R12: A window access with a4 or a5 set also loads the matching register during that same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| romsel_n | input | 1 | ROM-select from the console, active low |
| a12 | input | 1 | CPU address bit 12 |
| a11 | input | 1 | CPU address bit 11, window enable |
| a5 | input | 1 | CPU address bit 5, high register enable |
| a4 | input | 1 | CPU address bit 4, low register enable |
| a2 | input | 1 | CPU address bit 2, ROM/RAM pick |
| a0 | input | 1 | CPU address bit 0, top external address bit |
| m2 | input | 1 | CPU bus phase |
| rw | input | 1 | CPU direction, 1 = read |
| d | input | 8 | CPU data bus |
| rom_cs_n | output | 1 | External ROM chip select, active low |
| ram_cs_n | output | 1 | External RAM chip select, active low |
| ram_we_n | output | 1 | External RAM write strobe, active low |
| ext_addr | output | 17 | External memory address |
| chr_bank | output | 4 | CHR RAM bank select |

## Verification
The hardest situation to reach is a single access that selects external memory and also reloads one or both pointer registers. In that case the address seen on the same access changes partway through, once the register has captured the bus. The stimulus covers it with an exhaustive sweep over a11, a2, a4 and a5, run with both rw levels and with a fresh data byte on each step. The reference model updates its pointer before it predicts the held address. Separate steps remove one qualifier at a time and drop m2, to show that nothing loads.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int DATA_W = 8;
    localparam int BANK_W = 4;
    localparam int PTR_W  = 2 * DATA_W;
    localparam int EXT_W  = PTR_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } ptr_t;

    typedef struct packed {
        logic qual;
        logic load_lo;
        logic load_hi;
        logic window;
    } decode_t;
endpackage

// File: rtl/cycle_qualifier.sv
module cycle_qualifier
    import mapper_pkg::*;
(
    input  logic    romsel_n,
    input  logic    a12,
    input  logic    m2,
    input  logic    a11,
    input  logic    a5,
    input  logic    a4,
    output decode_t dec
);
    always_comb begin
        dec         = '0;
        dec.qual    = !romsel_n && a12 && m2;
        dec.load_lo = dec.qual && a4;
        dec.load_hi = dec.qual && a5;
        dec.window  = dec.qual && a11;
    end
endmodule

// File: rtl/pointer_regs.sv
module pointer_regs
    import mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [DATA_W-1:0] d,
    output ptr_t              ptr
);
    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_lo) ptr_d.lo = d;
        if (load_hi) ptr_d.hi = d;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R2 / R5: an enabled low register captures the bus byte
    a_r2_lo_load: assert property (@(posedge clk) disable iff (rst)
        load_lo |=> ptr_q.lo == $past(d));
    // R3 / R5
    a_r3_hi_load: assert property (@(posedge clk) disable iff (rst)
        load_hi |=> ptr_q.hi == $past(d));
    // R10 / R1: closed registers hold
    a_r10_lo_hold: assert property (@(posedge clk) disable iff (rst)
        !load_lo |=> $stable(ptr_q.lo));
    a_r10_hi_hold: assert property (@(posedge clk) disable iff (rst)
        !load_hi |=> $stable(ptr_q.hi));
    // R11
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> ptr_q == '0);
endmodule

// File: rtl/window_decode.sv
module window_decode
    import mapper_pkg::*;
(
    input  logic             window,
    input  logic             a2,
    input  logic             a0,
    input  logic             rw,
    input  ptr_t             ptr,
    output logic             rom_cs_n,
    output logic             ram_cs_n,
    output logic             ram_we_n,
    output logic [EXT_W-1:0] ext_addr,
    output logic [BANK_W-1:0] chr_bank
);
    always_comb begin
        rom_cs_n = !(window && !a2);
        ram_cs_n = !(window && a2);
        ram_we_n = ram_cs_n || rw;
        ext_addr = {a0, ptr.hi, ptr.lo};
        chr_bank = ptr.hi[DATA_W-1 -: BANK_W];
    end
endmodule

// File: rtl/indirect_mapper.sv
module indirect_mapper
    import mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 romsel_n,
    input  logic                 a12,
    input  logic                 a11,
    input  logic                 a5,
    input  logic                 a4,
    input  logic                 a2,
    input  logic                 a0,
    input  logic                 m2,
    input  logic                 rw,
    input  logic [7:0]           d,
    output logic                 rom_cs_n,
    output logic                 ram_cs_n,
    output logic                 ram_we_n,
    output logic [16:0]          ext_addr,
    output logic [3:0]           chr_bank
);
    decode_t dec;
    ptr_t    ptr;

    cycle_qualifier u_qual (
        .romsel_n(romsel_n), .a12(a12), .m2(m2),
        .a11(a11), .a5(a5), .a4(a4), .dec(dec)
    );

    pointer_regs u_regs (
        .clk(clk), .rst(rst),
        .load_lo(dec.load_lo), .load_hi(dec.load_hi),
        .d(d), .ptr(ptr)
    );

    window_decode u_win (
        .window(dec.window), .a2(a2), .a0(a0), .rw(rw), .ptr(ptr),
        .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ext_addr(ext_addr), .chr_bank(chr_bank)
    );

    // R6: selects exclusive
    a_r6_cs_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rom_cs_n == 1'b0 && ram_cs_n == 1'b0));
    // R1: no select outside a qualified cycle
    a_r1_no_cs_unqualified: assert property (@(posedge clk) disable iff (rst)
        (romsel_n || !a12 || !m2) |-> (rom_cs_n && ram_cs_n));
    // R8: write strobe only with RAM selected
    a_r8_we_needs_ram: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (!ram_cs_n && !rw));
    // R9: bank follows pointer high byte
    a_r9_bank_tracks: assert property (@(posedge clk) disable iff (rst)
        chr_bank == ext_addr[15:12]);
endmodule

// File: tb/indirect_mapper_test.sv
module indirect_mapper_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic romsel_n = 1'b1, a12 = 1'b0, a11 = 1'b0, a5 = 1'b0, a4 = 1'b0;
    logic a2 = 1'b0, a0 = 1'b0, m2 = 1'b0, rw = 1'b1;
    logic [7:0] d = 8'h00;
    logic rom_cs_n, ram_cs_n, ram_we_n;
    logic [16:0] ext_addr;
    logic [3:0] chr_bank;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic        rom_cs_n;
        logic        ram_cs_n;
        logic        ram_we_n;
        logic [16:0] addr;
        logic [3:0]  bank;
        string       tag;
    } exp_t;

    exp_t q[$];
    logic [7:0] m_lo = 8'h00, m_hi = 8'h00;
    bit done = 1'b0;

    always #4 clk = ~clk;

    indirect_mapper uut (
        .clk(clk), .rst(rst), .romsel_n(romsel_n), .a12(a12), .a11(a11),
        .a5(a5), .a4(a4), .a2(a2), .a0(a0), .m2(m2), .rw(rw), .d(d),
        .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ext_addr(ext_addr), .chr_bank(chr_bank)
    );

    task automatic push(input logic rc, input logic mc, input logic we, input string tag);
        exp_t e;
        e.rom_cs_n = rc;
        e.ram_cs_n = mc;
        e.ram_we_n = we;
        e.addr     = {a0, m_hi, m_lo};
        e.bank     = m_hi[7:4];
        e.tag      = tag;
        q.push_back(e);
    endtask

    // one bus access: qualifier bits given, m2 high for one clock, then falls
    task automatic access(input logic sel_n, input logic hi12, input logic w11,
                          input logic b2, input logic b4, input logic b5,
                          input logic b0, input logic r, input logic [7:0] val,
                          input string tag);
        logic qual, win;
        @(negedge clk);
        romsel_n = sel_n; a12 = hi12; a11 = w11; a2 = b2; a4 = b4; a5 = b5;
        a0 = b0; rw = r; d = val; m2 = 1'b1;
        qual = !sel_n && hi12;
        win  = qual && w11;
        if (qual && b4) m_lo = val;   // R2 R4 R12
        if (qual && b5) m_hi = val;   // R3 R5 R12
        @(posedge clk); #1;
        push(!(win && !b2), !(win && b2), !(win && b2 && !r), tag);
        @(negedge clk);
        m2 = 1'b0;
        d = ~val;                      // bus changes after m2 falls: must not load (R10)
        @(posedge clk); #1;
        push(1'b1, 1'b1, 1'b1, {tag, "/R10"});
    endtask

    // monitor: compare at each negedge with an item pending
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (rom_cs_n !== e.rom_cs_n || ram_cs_n !== e.ram_cs_n ||
                    ram_we_n !== e.ram_we_n || ext_addr !== e.addr || chr_bank !== e.bank) begin
                    bad++;
                    $display("FAIL %s: got cs=%b%b we=%b addr=%h bank=%h exp cs=%b%b we=%b addr=%h bank=%h",
                        e.tag, rom_cs_n, ram_cs_n, ram_we_n, ext_addr, chr_bank,
                        e.rom_cs_n, e.ram_cs_n, e.ram_we_n, e.addr, e.bank);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] seed;
        seed = 8'h3c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        push(1'b1, 1'b1, 1'b1, "R11 reset");

        // exhaustive: a11,a2,a4,a5 x rw x a0  (R2 R3 R4 R5 R6 R7 R8 R9 R12)
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 16; k++) begin
                for (int z = 0; z < 2; z++) begin
                    seed = seed * 8'd29 + 8'd71;
                    access(1'b0, 1'b1, k[3], k[2], k[1], k[0], z[0], r[0], seed,
                           "R2 R3 R4 R5 R6 R7 R8 R9 R12 sweep");
                end
            end
        end

        // R1: each qualifier removed alone, all enables set
        access(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5a, "R1 romsel off");
        access(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'ha5, "R1 a12 low");
        // m2 low only: drive everything but keep m2 low
        @(negedge clk);
        romsel_n = 1'b0; a12 = 1'b1; a11 = 1'b1; a4 = 1'b1; a5 = 1'b1; rw = 1'b0; d = 8'hee;
        @(posedge clk); #1;
        push(1'b1, 1'b1, 1'b1, "R1 m2 low");

        // R11 again: reset after loading
        access(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hc7, "R5 both");
        @(negedge clk);
        romsel_n = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_lo = 8'h00; m_hi = 8'h00; a0 = 1'b0;
        @(posedge clk); #1;
        push(1'b1, 1'b1, 1'b1, "R11 reset clears");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule